// File: doc/BRIEF.md
# Multi-cycle integer divider with condition codes

The block divides integers one quotient bit per clock, either unsigned or signed. In word mode a 32-bit dividend is divided by a 16-bit divisor. The 16-bit quotient and the 16-bit remainder are packed into a single destination value. In long mode the divisor is 32 bits wide, and the dividend is either one 32-bit operand or a 64-bit value built from two register operands. Quotient and remainder then go to two separately indexed destinations.

The surrounding datapath supplies the operand values, the destination register indices and the current N flag. It pulses `start` and later receives a one-cycle `done` pulse. With `done` come write enables, write data and condition-code outputs. When the divisor is zero, `done` instead carries a trap request and nothing is written. A quotient that does not fit the destination width is reported through V with the destination left untouched.

Top module: `intdiv_unit`

## Requirements
- R1: A `start` seen while `busy` is low is accepted and raises `busy` on the next cycle. A `start` seen while `busy` is high has no effect: the running result is unchanged and no extra `done` appears. Write enables, `flags_we` and `dz_trap` are only ever high together with `done`.
- R2: `done` is a one-cycle pulse. Counted from the accepting clock edge, it appears after 33 edges in word mode and in 32-bit long mode, after 65 edges in 64-bit long mode, and after 1 edge for a zero divisor.
- R3: The divisor is zero when its low 16 bits are zero (word mode) or all 32 bits are zero (long mode). A zero divisor gives `dz_trap`=1 with `done`, and `quo_we`, `rem_we` and `flags_we` stay 0.
- R4: Word mode (`op_long`=0, `op_wide` ignored) writes `quo_wdata` = {remainder[15:0], quotient[15:0]} to `quo_waddr` = `quo_idx`, with `rem_we`=0.
- R5: Word mode overflows when an unsigned quotient exceeds 0xFFFF, or when a signed quotient lies outside -32768..32767.
- R6: Long mode overflows when an unsigned quotient exceeds 0xFFFFFFFF, or when a signed quotient lies outside -2^31..2^31-1. This covers the 32-bit case -2^31 / -1.
- R7: On overflow, `flags_we`=1 with V=1, C=0, Z=0, and N equal to `n_prev` as sampled at the accepting edge. `quo_we` and `rem_we` are 0.
- R8: Without overflow, `flags_we`=1, C=0 and V=0. N is the quotient's sign bit (bit 15 in word mode, bit 31 in long mode), and Z is set when that 16- or 32-bit quotient is zero.
- R9: In 64-bit long mode (`op_long`=1, `op_wide`=1) the dividend is {`rem_val`, `quo_val`}. In the other modes the dividend is `quo_val` alone.
- R10: Long mode writes the 32-bit quotient to `quo_idx` and the remainder to `rem_idx`. When the two indices are equal, `rem_we`=0 and only the quotient is written.
- R11: Signed division truncates the quotient toward zero, and the remainder takes the sign of the dividend.
- R12: After reset, `busy`, `done`, `dz_trap`, `quo_we`, `rem_we` and `flags_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (taken only when idle) |
| op_long | input | 1 | 0 = word mode, 1 = long mode |
| op_wide | input | 1 | In long mode: 1 = 64-bit dividend |
| op_signed | input | 1 | Signed operands when 1 |
| quo_idx | input | 3 | Quotient destination index |
| rem_idx | input | 3 | Remainder destination index |
| quo_val | input | 32 | Dividend, or its low half in 64-bit mode |
| rem_val | input | 32 | High dividend half in 64-bit mode |
| divisor | input | 32 | Divisor (low 16 bits in word mode) |
| n_prev | input | 1 | Current N flag, kept on overflow |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | Divide-by-zero trap request |
| quo_we | output | 1 | Quotient destination write enable |
| quo_waddr | output | 3 | Quotient destination index |
| quo_wdata | output | 32 | Quotient destination value |
| rem_we | output | 1 | Remainder destination write enable |
| rem_waddr | output | 3 | Remainder destination index |
| rem_wdata | output | 32 | Remainder destination value |
| flags_we | output | 1 | Condition-code update strobe |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |

## Verification
A corrupted partial remainder or quotient shift register stays hidden until the completion pulse, so its first visible sign is a wrong value in `quo_wdata` or `rem_wdata`. That pulse comes 33 or 65 cycles after the start. A wrong iteration count or a stuck sequencer shows up as a `done` pulse in the wrong cycle, or no pulse at all. The scoreboard therefore checks the completion cycle as well as the data.

A mistake in the captured context shows up in the same pulse. A wrong sign flag gives a result of the wrong sign or a false overflow. A wrong mode gives the wrong packing or the wrong enable pattern. The bench drives sign combinations, range boundaries, equal indices and starts issued while the unit is busy.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
  typedef enum logic [1:0] {
    DM_WORD = 2'd0,
    DM_L32  = 2'd1,
    DM_L64  = 2'd2
  } dmode_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_RUN  = 2'd1,
    CS_FIN  = 2'd2
  } cstate_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
  import intdiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  dmode_e              mode,
  input  logic                is_signed,
  input  logic [XLEN-1:0]     lo,
  input  logic [XLEN-1:0]     hi,
  input  logic [XLEN-1:0]     den,
  output logic [2*XLEN-1:0]   dvd_aligned,
  output logic [XLEN-1:0]     den_mag,
  output logic                q_neg,
  output logic                r_neg,
  output logic                den_zero
);
  localparam int HALF = XLEN / 2;
  localparam int W2   = 2 * XLEN;

  logic [XLEN-1:0] den_ext;
  logic            den_neg;
  logic [W2-1:0]   dvd_ext;
  logic [W2-1:0]   dvd_mag;
  logic            dvd_neg;

  // Divisor: word mode narrows to the low half, then extends by signedness.
  always_comb begin
    if (mode == DM_WORD) begin
      if (is_signed) den_ext = {{HALF{den[HALF-1]}}, den[HALF-1:0]};
      else           den_ext = {{HALF{1'b0}}, den[HALF-1:0]};
    end else begin
      den_ext = den;
    end
    den_neg  = is_signed & den_ext[XLEN-1];
    den_mag  = den_neg ? (~den_ext + 1'b1) : den_ext;
    den_zero = (den_ext == '0);
  end

  // Dividend: the 64-bit form takes the high word from the second operand.
  always_comb begin
    if (mode == DM_L64) dvd_ext = {hi, lo};
    else                dvd_ext = {{XLEN{is_signed & lo[XLEN-1]}}, lo};
    dvd_neg = is_signed & dvd_ext[W2-1];
    dvd_mag = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
    // Narrow forms are left-aligned so the core always shifts from the top.
    if (mode == DM_L64) dvd_aligned = dvd_mag;
    else                dvd_aligned = {dvd_mag[XLEN-1:0], {XLEN{1'b0}}};
    q_neg = dvd_neg ^ den_neg;
    r_neg = dvd_neg;
  end
endmodule

// File: rtl/intdiv_core.sv
module intdiv_core
  import intdiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic              den_zero,
  input  logic              wide,
  input  logic [2*XLEN-1:0] dvd,
  input  logic [XLEN-1:0]   den,
  output logic              busy,
  output logic              fin,
  output logic [2*XLEN-1:0] dq_o,
  output logic [XLEN-1:0]   rem_o
);
  localparam int W2 = 2 * XLEN;
  localparam int CW = $clog2(W2);

  cstate_e         state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [XLEN-1:0] rem_q, rem_d;
  logic [W2-1:0]   dq_q, dq_d;
  logic [XLEN-1:0] den_q, den_d;
  logic            dp_en;

  // One restoring step: shift in the next dividend bit, trial subtract.
  logic [XLEN:0]   partial;
  logic [XLEN:0]   trial;
  logic            fits;
  logic [XLEN-1:0] rem_step;
  logic [W2-1:0]   dq_step;

  always_comb begin
    partial  = {rem_q, dq_q[W2-1]};
    trial    = partial - {1'b0, den_q};
    fits     = ~trial[XLEN];
    rem_step = fits ? trial[XLEN-1:0] : partial[XLEN-1:0];
    dq_step  = {dq_q[W2-2:0], fits};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    dq_d    = dq_q;
    den_d   = den_q;
    unique case (state_q)
      CS_IDLE: begin
        if (load) begin
          rem_d   = '0;
          dq_d    = dvd;
          den_d   = den;
          cnt_d   = wide ? CW'(W2 - 1) : CW'(XLEN - 1);
          state_d = den_zero ? CS_FIN : CS_RUN;
        end
      end
      CS_RUN: begin
        rem_d = rem_step;
        dq_d  = dq_step;
        if (cnt_q == '0) state_d = CS_FIN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      CS_FIN:  state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  assign dp_en = load | (state_q != CS_IDLE);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= CS_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (dp_en) begin
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      dq_q  <= dq_d;
      den_q <= den_d;
    end
  end

  assign busy  = (state_q != CS_IDLE);
  assign fin   = (state_q == CS_FIN);
  assign dq_o  = dq_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/intdiv_post.sv
module intdiv_post
  import intdiv_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDXW = 3
) (
  input  dmode_e            mode,
  input  logic              is_signed,
  input  logic              q_neg,
  input  logic              r_neg,
  input  logic              n_prev,
  input  logic              den_zero,
  input  logic [IDXW-1:0]   qidx,
  input  logic [IDXW-1:0]   ridx,
  input  logic [2*XLEN-1:0] dq,
  input  logic [XLEN-1:0]   rem,
  output logic              quo_we,
  output logic [XLEN-1:0]   quo_wd,
  output logic              rem_we,
  output logic [XLEN-1:0]   rem_wd,
  output logic              flags_we,
  output ccr_t              ccr,
  output logic              dz
);
  localparam int HALF = XLEN / 2;
  localparam int W2   = 2 * XLEN;
  localparam logic [W2-1:0] ONE    = W2'(1);
  localparam logic [W2-1:0] LIM_WU = (ONE << HALF) - ONE;
  localparam logic [W2-1:0] LIM_WP = (ONE << (HALF - 1)) - ONE;
  localparam logic [W2-1:0] LIM_WN = ONE << (HALF - 1);
  localparam logic [W2-1:0] LIM_LU = (ONE << XLEN) - ONE;
  localparam logic [W2-1:0] LIM_LP = (ONE << (XLEN - 1)) - ONE;
  localparam logic [W2-1:0] LIM_LN = ONE << (XLEN - 1);

  logic [W2-1:0]   qmag;
  logic [W2-1:0]   lim;
  logic            ovf;
  logic [XLEN-1:0] qres;
  logic [XLEN-1:0] rres;
  logic            is_word;

  always_comb begin
    is_word = (mode == DM_WORD);
    qmag    = (mode == DM_L64) ? dq : {{XLEN{1'b0}}, dq[XLEN-1:0]};
    // Largest magnitude that the destination can hold for this sign.
    if (is_word) lim = !is_signed ? LIM_WU : (q_neg ? LIM_WN : LIM_WP);
    else         lim = !is_signed ? LIM_LU : (q_neg ? LIM_LN : LIM_LP);
    ovf  = (qmag > lim);
    qres = q_neg ? (~qmag[XLEN-1:0] + 1'b1) : qmag[XLEN-1:0];
    rres = r_neg ? (~rem + 1'b1) : rem;
  end

  always_comb begin
    quo_we   = 1'b0;
    rem_we   = 1'b0;
    flags_we = 1'b0;
    dz       = 1'b0;
    ccr      = '0;
    quo_wd   = qres;
    rem_wd   = rres;
    if (is_word) quo_wd = {rres[HALF-1:0], qres[HALF-1:0]};
    if (den_zero) begin
      dz = 1'b1;
    end else if (ovf) begin
      flags_we = 1'b1;
      ccr      = '{n: n_prev, z: 1'b0, v: 1'b1, c: 1'b0};
    end else begin
      flags_we = 1'b1;
      quo_we   = 1'b1;
      rem_we   = !is_word && (ridx != qidx);
      if (is_word) ccr = '{n: qres[HALF-1], z: (qres[HALF-1:0] == '0), v: 1'b0, c: 1'b0};
      else         ccr = '{n: qres[XLEN-1], z: (qres == '0), v: 1'b0, c: 1'b0};
    end
  end
endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
  import intdiv_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_long,
  input  logic            op_wide,
  input  logic            op_signed,
  input  logic [IDXW-1:0] quo_idx,
  input  logic [IDXW-1:0] rem_idx,
  input  logic [XLEN-1:0] quo_val,
  input  logic [XLEN-1:0] rem_val,
  input  logic [XLEN-1:0] divisor,
  input  logic            n_prev,
  output logic            busy,
  output logic            done,
  output logic            dz_trap,
  output logic            quo_we,
  output logic [IDXW-1:0] quo_waddr,
  output logic [XLEN-1:0] quo_wdata,
  output logic            rem_we,
  output logic [IDXW-1:0] rem_waddr,
  output logic [XLEN-1:0] rem_wdata,
  output logic            flags_we,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  localparam int W2 = 2 * XLEN;

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  dmode_e          mode_in;
  logic            accept;
  logic [W2-1:0]   dvd_al;
  logic [XLEN-1:0] den_mag;
  logic            qneg_in, rneg_in, dz_in;
  logic            core_busy, core_fin;
  logic [W2-1:0]   core_dq;
  logic [XLEN-1:0] core_rem;

  assign mode_in = !op_long ? DM_WORD : (op_wide ? DM_L64 : DM_L32);
  assign accept  = start & ~core_busy;

  intdiv_prep #(.XLEN(XLEN)) u_prep (
    .mode        (mode_in),
    .is_signed   (op_signed),
    .lo          (quo_val),
    .hi          (rem_val),
    .den         (divisor),
    .dvd_aligned (dvd_al),
    .den_mag     (den_mag),
    .q_neg       (qneg_in),
    .r_neg       (rneg_in),
    .den_zero    (dz_in)
  );

  // Context held for the whole operation.
  dmode_e          mode_q, mode_d;
  logic            sgn_q, sgn_d, qneg_q, qneg_d, rneg_q, rneg_d;
  logic            np_q, np_d, dz_q, dz_d;
  logic [IDXW-1:0] qidx_q, qidx_d, ridx_q, ridx_d;

  always_comb begin
    mode_d = mode_q;   sgn_d  = sgn_q;   qneg_d = qneg_q;
    rneg_d = rneg_q;   np_d   = np_q;    dz_d   = dz_q;
    qidx_d = qidx_q;   ridx_d = ridx_q;
    if (accept) begin
      mode_d = mode_in;  sgn_d  = op_signed; qneg_d = qneg_in;
      rneg_d = rneg_in;  np_d   = n_prev;    dz_d   = dz_in;
      qidx_d = quo_idx;  ridx_d = rem_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mode_q <= mode_d;  sgn_q  <= sgn_d;  qneg_q <= qneg_d;
      rneg_q <= rneg_d;  np_q   <= np_d;   dz_q   <= dz_d;
      qidx_q <= qidx_d;  ridx_q <= ridx_d;
    end
  end

  intdiv_core #(.XLEN(XLEN)) u_core (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (accept),
    .den_zero (dz_in),
    .wide     (mode_in == DM_L64),
    .dvd      (dvd_al),
    .den      (den_mag),
    .busy     (core_busy),
    .fin      (core_fin),
    .dq_o     (core_dq),
    .rem_o    (core_rem)
  );

  logic            p_quo_we, p_rem_we, p_flags_we, p_dz;
  logic [XLEN-1:0] p_quo_wd, p_rem_wd;
  ccr_t            p_ccr;

  intdiv_post #(.XLEN(XLEN), .IDXW(IDXW)) u_post (
    .mode      (mode_q),
    .is_signed (sgn_q),
    .q_neg     (qneg_q),
    .r_neg     (rneg_q),
    .n_prev    (np_q),
    .den_zero  (dz_q),
    .qidx      (qidx_q),
    .ridx      (ridx_q),
    .dq        (core_dq),
    .rem       (core_rem),
    .quo_we    (p_quo_we),
    .quo_wd    (p_quo_wd),
    .rem_we    (p_rem_we),
    .rem_wd    (p_rem_wd),
    .flags_we  (p_flags_we),
    .ccr       (p_ccr),
    .dz        (p_dz)
  );

  // Result stage: strobes pulse with done, data holds between results.
  logic            done_d, dz_d2, qwe_d, rwe_d, fwe_d;
  logic [IDXW-1:0] qwa_d, rwa_d;
  logic [XLEN-1:0] qwd_d, rwd_d;
  ccr_t            ccr_q, ccr_d;

  always_comb begin
    done_d = core_fin;
    dz_d2  = core_fin & p_dz;
    qwe_d  = core_fin & p_quo_we;
    rwe_d  = core_fin & p_rem_we;
    fwe_d  = core_fin & p_flags_we;
    qwa_d  = quo_waddr;  rwa_d = rem_waddr;
    qwd_d  = quo_wdata;  rwd_d = rem_wdata;
    ccr_d  = ccr_q;
    if (core_fin) begin
      qwa_d = qidx_q;    rwa_d = ridx_q;
      qwd_d = p_quo_wd;  rwd_d = p_rem_wd;
      if (p_flags_we) ccr_d = p_ccr;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      done <= 1'b0;  dz_trap <= 1'b0;  quo_we <= 1'b0;
      rem_we <= 1'b0;  flags_we <= 1'b0;
      quo_waddr <= '0;  rem_waddr <= '0;
      quo_wdata <= '0;  rem_wdata <= '0;
      ccr_q <= '0;
    end else begin
      done <= done_d;  dz_trap <= dz_d2;  quo_we <= qwe_d;
      rem_we <= rwe_d;  flags_we <= fwe_d;
      quo_waddr <= qwa_d;  rem_waddr <= rwa_d;
      quo_wdata <= qwd_d;  rem_wdata <= rwd_d;
      ccr_q <= ccr_d;
    end
  end

  assign busy   = core_busy;
  assign flag_n = ccr_q.n;
  assign flag_z = ccr_q.z;
  assign flag_v = ccr_q.v;
  assign flag_c = ccr_q.c;
endmodule

// File: rtl/intdiv_unit_chk.sv
module intdiv_unit_chk #(
  parameter int XLEN = 32,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            n_prev,
  input logic            busy,
  input logic            done,
  input logic            dz_trap,
  input logic            quo_we,
  input logic [IDXW-1:0] quo_waddr,
  input logic            rem_we,
  input logic [IDXW-1:0] rem_waddr,
  input logic            flags_we,
  input logic            flag_n,
  input logic            flag_z,
  input logic            flag_v,
  input logic            flag_c
);
  localparam int LW = $clog2(2 * XLEN + 3) + 1;

  logic [1:0]    rdy_q;
  logic          seen_acc;
  logic [LW-1:0] lat_q;
  logic          np_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 2'b00;
    else        rdy_q <= {rdy_q[0], 1'b1};
  end
  assign seen_acc = start & ~busy & rdy_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      np_cap <= 1'b0;
    end else begin
      if (seen_acc)           lat_q <= LW'(1);
      else if (done)          lat_q <= '0;
      else if (lat_q != '0)   lat_q <= lat_q + 1'b1;
      if (seen_acc) np_cap <= n_prev;
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_acc |=> busy);
  assert_strobe_in_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (quo_we || rem_we || flags_we || dz_trap) |-> done);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(2) || lat_q == LW'(XLEN + 2) || lat_q == LW'(2 * XLEN + 2)));
  assert_dz_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> (!quo_we && !rem_we && !flags_we));
  assert_ovf_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && flag_v) |-> (!quo_we && !rem_we && !flag_c && !flag_z && flag_n == np_cap));
  assert_clean_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && !flag_v) |-> (!flag_c && quo_we));
  assert_rem_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rem_we |-> (quo_we && rem_waddr != quo_waddr));
endmodule

bind intdiv_unit intdiv_unit_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .n_prev(n_prev), .busy(busy),
  .done(done), .dz_trap(dz_trap), .quo_we(quo_we), .quo_waddr(quo_waddr),
  .rem_we(rem_we), .rem_waddr(rem_waddr), .flags_we(flags_we),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/test_intdiv_unit.sv
module test_intdiv_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_long = 1'b0, op_wide = 1'b0, op_signed = 1'b0, n_prev = 1'b0;
  logic [2:0]  quo_idx = '0, rem_idx = '0;
  logic [31:0] quo_val = '0, rem_val = '0, divisor = '0;
  logic busy, done, dz_trap, quo_we, rem_we, flags_we, flag_n, flag_z, flag_v, flag_c;
  logic [2:0]  quo_waddr, rem_waddr;
  logic [31:0] quo_wdata, rem_wdata;

  always #5 clk = ~clk;

  intdiv_unit i_intdiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_long(op_long), .op_wide(op_wide),
    .op_signed(op_signed), .quo_idx(quo_idx), .rem_idx(rem_idx), .quo_val(quo_val),
    .rem_val(rem_val), .divisor(divisor), .n_prev(n_prev), .busy(busy), .done(done),
    .dz_trap(dz_trap), .quo_we(quo_we), .quo_waddr(quo_waddr), .quo_wdata(quo_wdata),
    .rem_we(rem_we), .rem_waddr(rem_waddr), .rem_wdata(rem_wdata), .flags_we(flags_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  typedef struct {
    bit dz; bit qwe; bit [31:0] qwd; bit [2:0] qwa;
    bit rwe; bit [31:0] rwd; bit [2:0] rwa;
    bit fwe; bit [3:0] nzvc; int unsigned at; string req;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R1", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(cyc == e.at, "R2", {e.req, " completion cycle"}, cyc, e.at);
        chk(dz_trap == e.dz && quo_we == e.qwe && rem_we == e.rwe && flags_we == e.fwe,
            e.req, "strobes {dz,qwe,rwe,fwe}", {dz_trap, quo_we, rem_we, flags_we},
            {e.dz, e.qwe, e.rwe, e.fwe});
        if (e.qwe) chk(quo_wdata == e.qwd && quo_waddr == e.qwa, e.req, "quotient write",
                       {quo_waddr, quo_wdata}, {e.qwa, e.qwd});
        if (e.rwe) chk(rem_wdata == e.rwd && rem_waddr == e.rwa, e.req, "remainder write",
                       {rem_waddr, rem_wdata}, {e.rwa, e.rwd});
        if (e.fwe) chk({flag_n, flag_z, flag_v, flag_c} == e.nzvc, e.req, "flags NZVC",
                       {flag_n, flag_z, flag_v, flag_c}, e.nzvc);
      end
    end
  end

  // Reference from the requirements: wide signed arithmetic, then range checks.
  function automatic exp_t model(input bit lng, input bit wide, input bit sgn,
                                 input bit [31:0] lo, input bit [31:0] hi,
                                 input bit [31:0] den, input bit [2:0] qi,
                                 input bit [2:0] ri, input bit np);
    exp_t e;
    logic signed [127:0] nn, dd, qq, rr;
    bit ovf;
    e = '{dz: 0, qwe: 0, qwd: 0, qwa: qi, rwe: 0, rwd: 0, rwa: ri, fwe: 0, nzvc: 0, at: 0, req: ""};
    if (!lng) dd = sgn ? {{112{den[15]}}, den[15:0]} : {112'b0, den[15:0]};
    else      dd = sgn ? {{96{den[31]}}, den} : {96'b0, den};
    if (lng && wide) nn = sgn ? {{64{hi[31]}}, hi, lo} : {64'b0, hi, lo};
    else             nn = sgn ? {{96{lo[31]}}, lo} : {96'b0, lo};
    if (dd == 0) begin
      e.dz = 1;
      return e;
    end
    qq = nn / dd;
    rr = nn % dd;
    if (!lng) ovf = sgn ? (qq > 128'sd32767 || qq < -128'sd32768) : (qq > 128'sd65535);
    else      ovf = sgn ? (qq > 128'sd2147483647 || qq < -128'sd2147483648)
                        : (qq > 128'sd4294967295);
    e.fwe = 1;
    if (ovf) begin
      e.nzvc = {np, 1'b0, 1'b1, 1'b0};
    end else if (!lng) begin
      e.qwe  = 1;
      e.qwd  = {rr[15:0], qq[15:0]};
      e.nzvc = {qq[15], qq[15:0] == 16'd0, 2'b00};
    end else begin
      e.qwe  = 1;
      e.qwd  = qq[31:0];
      e.rwe  = (qi != ri);
      e.rwd  = rr[31:0];
      e.nzvc = {qq[31], qq[31:0] == 32'd0, 2'b00};
    end
    return e;
  endfunction

  // Driver: applies one operation, pushes its expectation, waits for idle.
  task automatic run_op(input bit lng, input bit wide, input bit sgn,
                        input bit [31:0] lo, input bit [31:0] hi, input bit [31:0] den,
                        input bit [2:0] qi, input bit [2:0] ri, input bit np,
                        input string req, input bit poke_busy);
    exp_t e;
    e = model(lng, wide, sgn, lo, hi, den, qi, ri, np);
    e.req = req;
    @(negedge clk);
    op_long = lng; op_wide = wide; op_signed = sgn; quo_val = lo; rem_val = hi;
    divisor = den; quo_idx = qi; rem_idx = ri; n_prev = np; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e.at = cyc + (e.dz ? 1 : ((lng && wide) ? 65 : 33));
    sbq.push_back(e);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      // R1: a start while busy, with different operands, must be ignored.
      quo_val = 32'h1234_5678; divisor = 32'h0000_0003; n_prev = ~np;
      op_long = ~lng; quo_idx = ~qi; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: idle after reset.
    chk(!busy && !done && !dz_trap && !quo_we && !rem_we && !flags_we, "R12",
        "reset outputs", {busy, done, dz_trap, quo_we, rem_we, flags_we}, 0);

    // Word mode, unsigned (R4, R8).
    run_op(0, 0, 0, 32'd100000, 0, 32'd7, 3'd2, 3'd5, 0, "R4", 0);
    run_op(0, 1, 0, 32'd5, 32'hFFFF_FFFF, 32'hABCD_0009, 3'd1, 3'd1, 1, "R8", 0);
    // Word overflow, unsigned; N kept from n_prev (R5, R7).
    run_op(0, 0, 0, 32'h0010_0000, 0, 32'd1, 3'd0, 3'd0, 1, "R5", 0);
    run_op(0, 0, 0, 32'h0001_0000, 0, 32'd1, 3'd0, 3'd0, 0, "R7", 0);
    // Word signed signs (R11).
    run_op(0, 0, 1, -32'sd7, 0, 32'd2, 3'd4, 3'd0, 0, "R11", 0);
    run_op(0, 0, 1, 32'd7, 0, 32'h0000_FFFE, 3'd4, 3'd0, 0, "R11", 0);
    run_op(0, 0, 1, 32'd32767, 0, 32'h0000_8000, 3'd6, 3'd0, 0, "R11", 0);
    // Word signed boundaries (R5).
    run_op(0, 0, 1, -32'sd65536, 0, 32'd2, 3'd3, 3'd0, 0, "R5", 0);
    run_op(0, 0, 1, 32'd65536, 0, 32'd2, 3'd3, 3'd0, 1, "R5", 0);
    run_op(0, 0, 1, -32'sd65538, 0, 32'd2, 3'd3, 3'd0, 0, "R5", 0);
    // Zero divisor: low 16 bits zero in word mode, all bits in long (R3).
    run_op(0, 0, 0, 32'd77, 0, 32'h0001_0000, 3'd1, 3'd2, 0, "R3", 0);
    run_op(1, 0, 1, 32'd77, 0, 32'd0, 3'd1, 3'd2, 0, "R3", 0);
    run_op(1, 1, 0, 32'd77, 32'd1, 32'd0, 3'd1, 3'd2, 0, "R3", 0);
    // Long 32-bit (R10, R11, R6).
    run_op(1, 0, 0, 32'hFFFF_FFFF, 0, 32'h10, 3'd1, 3'd2, 0, "R10", 0);
    run_op(1, 0, 0, 32'hFFFF_FFFF, 0, 32'h10, 3'd3, 3'd3, 0, "R10", 0);
    run_op(1, 0, 1, -32'sd100, 0, 32'd7, 3'd0, 3'd7, 0, "R11", 0);
    run_op(1, 0, 1, 32'h8000_0000, 0, 32'hFFFF_FFFF, 3'd0, 3'd7, 1, "R6", 0);
    // Long 64-bit dividend formed from {rem_val, quo_val} (R9, R6).
    run_op(1, 1, 0, 32'd0, 32'd1, 32'd2, 3'd2, 3'd4, 0, "R9", 0);
    run_op(1, 1, 0, 32'd0, 32'd5, 32'd3, 3'd2, 3'd4, 0, "R6", 0);
    run_op(1, 1, 1, -32'sd10, 32'hFFFF_FFFF, 32'd3, 3'd2, 3'd4, 0, "R9", 0);
    run_op(1, 1, 1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd1, 3'd2, 3'd4, 0, "R6", 0);
    run_op(1, 1, 1, 32'h8000_0000, 32'd0, 32'd1, 3'd2, 3'd4, 1, "R6", 0);
    // Starts issued while busy (R1).
    run_op(0, 0, 0, 32'd1000, 0, 32'd9, 3'd5, 3'd1, 0, "R1", 1);
    run_op(1, 1, 1, 32'h0000_0100, 32'd3, 32'hFFFF_FFF0, 3'd5, 3'd1, 0, "R1", 1);
    repeat (40) @(negedge clk);
    // R2: mixed random operations.
    for (int k = 0; k < 12; k++) begin
      bit [31:0] a, b, d;
      a = $urandom; b = $urandom; d = $urandom;
      if (k % 3 == 0) b = {28'b0, b[3:0]};
      run_op(k[0], k[1], k[2], a, b, d, 3'($urandom), 3'($urandom), k[3], "R2", 0);
    end
    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R2", "results outstanding", sbq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule